// File: doc/BRIEF.md
# Chip-Select Row Matcher with Spare Remap

This block answers one question for a memory controller: which chip-select row on a chosen channel owns a given 32-bit input address. Each channel has eight rows, and each row has a base word and a mask word. Software fills these words, together with a small spare-control word, through a single-cycle register write port. An upstream stage normalises the address and picks the channel. It then raises a lookup request.

A lookup scans the rows of the selected channel one per clock, starting at row 0. The first enabled row whose unmasked bits agree with the address ends the scan. The block then pulses `done` and reports `found` and `row`. If online sparing has retired the matched row on that channel, the reported row is replaced by the channel's spare rank. The base and mask words live in RAM with a registered read, so a lookup takes between two and nine cycles. While a lookup is running, `busy` stays high and any new request is dropped.

Top module: `csrow_match_unit`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` according to `wr_kind`. Kind 0 goes to the base word of (`wr_chan`, `wr_row`), kind 1 goes to the mask word of that row, kind 2 goes to the spare-control word, and kind 3 stores nothing. Every later lookup uses the stored values.
- R2: Bit 0 of a base word enables its row. A row with this bit clear never matches, whatever its other bits hold.
- R3: Before comparison, the mask is forced to have bits 18:14 and 4:0 set and bits 31:29 clear. Because of this, address bits 31:29 must be zero for any match.
- R4: Before comparison, the base is cut down to bits 28:19 and 13:5. Any other base bit, including bits 31:29, has no effect.
- R5: A row matches when (address AND NOT mask) equals (reduced base AND NOT mask). Rows are tried in ascending order, and the lowest matching row is reported.
- R6: When no enabled row of the channel matches, `found` is 0 and `row` is 0.
- R7: The spare-control word holds one field per channel. For channel 0, bit 0 is swap-done and bits 3:1 are the bad row. For channel 1, bit 4 is swap-done and bits 7:5 are the bad row. When the matched row equals the bad row and swap-done is set, the channel's spare rank (0 for channel 0, 1 for channel 1) is reported instead.
- R8: A request is accepted on an edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until `done`. `done` is a one-cycle pulse that appears r+2 edges after acceptance when row r matches, or 9 edges after acceptance when nothing matches.
- R9: A request presented while `busy` is high is ignored. It produces no extra `done`, and it does not change the lookup in flight.
- R10: After reset, `busy`, `done`, `found` and `row` are all 0. `found` and `row` keep their values between `done` pulses.
- R11: A lookup uses only the rows of `req_chan`. Rows of the other channel never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 base, 1 mask, 2 spare control, 3 none |
| wr_chan | input | 1 | Channel of the base or mask write |
| wr_row | input | 3 | Row of the base or mask write |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request |
| req_chan | input | 1 | Channel to search |
| req_addr | input | 32 | Input address |
| busy | output | 1 | Lookup in progress; requests are dropped |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | An enabled row matched |
| row | output | 3 | Reported row, after spare remap |

## Verification
The bench puts several rows on one address so that both could claim it. A matcher that picked the last match instead of the first would report the wrong row and finish late. Some rows are disabled but hold a mask that accepts any address. Other rows carry stray base bits outside the defined field, and some addresses set bits in the forced-mask region or above bit 28. A design that skipped the enable test, the mask forcing or the base reduction would then report a row where none exists, or none where one does. The spare remap is tested with swap-done both clear and set, and on both the bad row and a healthy row; an inverted condition or a swapped channel would show in `row`. A request held high while busy, and the done-to-done latency for every row position, catch a scanner that restarts, double-reports or mis-counts its pipeline.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int unsigned WORD_W = 32;

  // mask bits always treated as don't-care
  localparam logic [WORD_W-1:0] MASK_FORCE_ON  = 32'h0007_C01F;
  // mask bits kept from the register (bits above 28 cleared)
  localparam logic [WORD_W-1:0] MASK_KEEP      = 32'h1FFF_FFFF;
  // base bits that take part in the comparison
  localparam logic [WORD_W-1:0] BASE_FIELD     = 32'h1FF8_3FE0;
  localparam int unsigned       BASE_EN_BIT    = 0;

  typedef enum logic [1:0] {
    WK_BASE  = 2'd0,
    WK_MASK  = 2'd1,
    WK_SPARE = 2'd2,
    WK_NONE  = 2'd3
  } wr_kind_e;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/csm_regbank.sv
module csm_regbank
  import csm_pkg::*;
#(
  parameter int CHANS = 2,
  parameter int ROWS  = 8,
  localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1,
  localparam int ROW_W = $clog2(ROWS),
  localparam int FLD_W = 1 + ROW_W,
  localparam int SP_W  = CHANS * FLD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_kind,
  input  logic [CH_W-1:0]         wr_chan,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [CH_W-1:0]         rd_chan,
  input  logic [ROW_W-1:0]        rd_row,
  output logic [WORD_W-1:0]       rd_base,
  output logic [WORD_W-1:0]       rd_mask,
  output logic [CHANS-1:0]        spare_swap,
  output logic [CHANS*ROW_W-1:0]  spare_bad
);
  localparam int IDX_W = CH_W + ROW_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] base_mem [0:DEPTH-1];
  logic [WORD_W-1:0] mask_mem [0:DEPTH-1];
  logic [SP_W-1:0]   spare_q;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  assign wr_idx = {wr_chan, wr_row};
  assign rd_idx = {rd_chan, rd_row};

  // two simple-dual-port RAMs, registered read
  always_ff @(posedge clk) begin
    if (wr_en && wr_kind == WK_BASE) base_mem[wr_idx] <= wr_data;
    rd_base <= base_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_kind == WK_MASK) mask_mem[wr_idx] <= wr_data;
    rd_mask <= mask_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)                                spare_q <= '0;
    else if (wr_en && wr_kind == WK_SPARE)  spare_q <= wr_data[SP_W-1:0];
  end

  // per-channel field: swap-done in the low bit, bad row above it
  for (genvar c = 0; c < CHANS; c++) begin : g_spare
    assign spare_swap[c]                  = spare_q[c*FLD_W];
    assign spare_bad[c*ROW_W +: ROW_W]    = spare_q[c*FLD_W+1 +: ROW_W];
  end
endmodule

// File: rtl/csm_row_cmp.sv
module csm_row_cmp
  import csm_pkg::*;
(
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] mask,
  output logic              hit
);
  logic [WORD_W-1:0] eff_mask, eff_base, care;

  always_comb begin
    eff_mask = (mask | MASK_FORCE_ON) & MASK_KEEP;
    eff_base = base & BASE_FIELD;
    care     = ~eff_mask;
    hit      = base[BASE_EN_BIT] && ((addr & care) == (eff_base & care));
  end
endmodule

// File: rtl/csm_spare_remap.sv
module csm_spare_remap #(
  parameter int CHANS = 2,
  parameter int ROWS  = 8,
  localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [CH_W-1:0]        chan,
  input  logic [ROW_W-1:0]       row_in,
  input  logic [CHANS-1:0]       swap,
  input  logic [CHANS*ROW_W-1:0] bad,
  output logic [ROW_W-1:0]       row_out
);
  // spare rank of channel c is row c
  always_comb begin
    row_out = row_in;
    for (int c = 0; c < CHANS; c++) begin
      if (chan == CH_W'(c) && swap[c] && row_in == bad[c*ROW_W +: ROW_W])
        row_out = ROW_W'(c);
    end
  end
endmodule

// File: rtl/csm_scan_ctl.sv
module csm_scan_ctl
  import csm_pkg::*;
#(
  parameter int CHANS = 2,
  parameter int ROWS  = 8,
  localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [WORD_W-1:0] req_addr,
  input  logic              hit,
  output logic [CH_W-1:0]   chan_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [ROW_W-1:0]  rd_row,
  output logic [ROW_W-1:0]  cmp_row,
  output logic              busy,
  output logic              finish
);
  scan_st_e         st_q;
  logic [ROW_W-1:0] issue_q, cmp_q;
  logic             cmp_vld_q;

  assign busy    = (st_q == SC_SCAN);
  assign rd_row  = issue_q;
  assign cmp_row = cmp_q;
  assign finish  = busy && cmp_vld_q && (hit || cmp_q == ROW_W'(ROWS - 1));

  // issue row k, compare it one cycle later when RAM data returns
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SC_IDLE;
      issue_q   <= '0;
      cmp_q     <= '0;
      cmp_vld_q <= 1'b0;
      chan_q    <= '0;
      addr_q    <= '0;
    end else begin
      cmp_vld_q <= 1'b0;
      case (st_q)
        SC_IDLE: begin
          if (req_valid) begin
            st_q    <= SC_SCAN;
            issue_q <= '0;
            chan_q  <= req_chan;
            addr_q  <= req_addr;
          end
        end
        SC_SCAN: begin
          issue_q   <= issue_q + 1'b1;
          cmp_q     <= issue_q;
          cmp_vld_q <= !finish;
          if (finish) st_q <= SC_IDLE;
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csrow_match_unit.sv
module csrow_match_unit
  import csm_pkg::*;
#(
  parameter int CHANS = 2,
  parameter int ROWS  = 8,
  localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [WORD_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [ROW_W-1:0]  row
);
  logic [CH_W-1:0]        chan_q;
  logic [WORD_W-1:0]      addr_q, rd_base, rd_mask;
  logic [ROW_W-1:0]       rd_row, cmp_row, remapped;
  logic [CHANS-1:0]       spare_swap;
  logic [CHANS*ROW_W-1:0] spare_bad;
  logic                   hit, finish;

  csm_regbank #(.CHANS(CHANS), .ROWS(ROWS)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_chan(wr_chan), .wr_row(wr_row),
    .wr_data(wr_data),
    .rd_chan(chan_q), .rd_row(rd_row),
    .rd_base(rd_base), .rd_mask(rd_mask),
    .spare_swap(spare_swap), .spare_bad(spare_bad)
  );

  csm_scan_ctl #(.CHANS(CHANS), .ROWS(ROWS)) u_scan (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_chan(req_chan), .req_addr(req_addr),
    .hit(hit),
    .chan_q(chan_q), .addr_q(addr_q),
    .rd_row(rd_row), .cmp_row(cmp_row),
    .busy(busy), .finish(finish)
  );

  csm_row_cmp u_cmp (
    .addr(addr_q), .base(rd_base), .mask(rd_mask), .hit(hit)
  );

  csm_spare_remap #(.CHANS(CHANS), .ROWS(ROWS)) u_spare (
    .chan(chan_q), .row_in(cmp_row),
    .swap(spare_swap), .bad(spare_bad),
    .row_out(remapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      found <= 1'b0;
      row   <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        found <= hit;
        row   <= hit ? remapped : '0;
      end
    end
  end
endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
  parameter int ROWS = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic             found,
  input logic [ROW_W-1:0] row
);
  // R8: result strobe lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: accepted request makes the block busy
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R8: busy is gone when the result appears
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: busy only ends together with a result
  a_r8_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: a result always follows a busy cycle
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R6: a miss reports row zero
  a_r6_miss_row_zero: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (row == '0));

  // R10: result held between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(found) && $stable(row)));
endmodule

bind csrow_match_unit csm_checker #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .done(done), .found(found), .row(row)
);

// File: tb/sim_csrow_match_unit.sv
module sim_csrow_match_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        chan;
    logic [31:0] addr;
    logic        found;
    logic [2:0]  row;
    logic [3:0]  lat;
  } vec_t;

  // R5 R6 R11 R3 R4 R7 table: channel, address, found, row, latency
  localparam vec_t VECS [0:13] = '{
    '{1'b0, 32'h0028_1234, 1'b1, 3'd1, 4'd3},  // R5 rows 1 and 2 overlap
    '{1'b0, 32'h0030_0000, 1'b1, 3'd2, 4'd4},  // R5 only row 2
    '{1'b0, 32'h0048_41BF, 1'b1, 3'd3, 4'd5},  // R3 forced bits ignored
    '{1'b0, 32'h0048_01C0, 1'b0, 3'd0, 4'd9},  // R2 only disabled row0 covers it
    '{1'b0, 32'h0060_0000, 1'b1, 3'd4, 4'd6},  // R4 stray base bit 30
    '{1'b0, 32'h00A0_0040, 1'b1, 3'd5, 4'd7},  // R7 swap not done
    '{1'b0, 32'h00F8_0000, 1'b1, 3'd7, 4'd9},  // R8 last row
    '{1'b0, 32'h0100_0000, 1'b0, 3'd0, 4'd9},  // R6 miss
    '{1'b1, 32'h0028_0000, 1'b1, 3'd0, 4'd2},  // R11 channel 1 row 0
    '{1'b1, 32'h0148_0000, 1'b1, 3'd1, 4'd4},  // R7 row 2 spared to 1
    '{1'b1, 32'h0150_0000, 1'b1, 3'd3, 4'd5},  // R7 healthy row
    '{1'b0, 32'h2028_0000, 1'b0, 3'd0, 4'd9},  // R3 bit 29 set
    '{1'b1, 32'h00F8_0000, 1'b0, 3'd0, 4'd9},  // R11 ch0 row not visible
    '{1'b1, 32'h0158_0000, 1'b0, 3'd0, 4'd9}   // R1 before mask rewrite
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_kind;
  logic        wr_chan;
  logic [2:0]  wr_row;
  logic [31:0] wr_data;
  logic        req_valid;
  logic        req_chan;
  logic [31:0] req_addr;
  logic        busy, done, found;
  logic [2:0]  row;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csrow_match_unit u0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_chan(wr_chan), .wr_row(wr_row),
    .wr_data(wr_data),
    .req_valid(req_valid), .req_chan(req_chan), .req_addr(req_addr),
    .busy(busy), .done(done), .found(found), .row(row)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input logic ch,
                    input logic [2:0] r, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_chan = ch; wr_row = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_lookup(input logic ch, input logic [31:0] a,
                            input logic exp_f, input logic [2:0] exp_r,
                            input int exp_lat, input string tag);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_addr = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      #1 lat++;
    end while (!done && lat < 40);
    chk(found == exp_f, {tag, " found"}, 32'(found), 32'(exp_f));
    chk(row == exp_r,   {tag, " row"},   32'(row),   32'(exp_r));
    chk(lat == exp_lat, {tag, " R8 latency"}, 32'(lat), 32'(exp_lat));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R8 watchdog: actual expired expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_kind = 2'd3; wr_chan = 1'b0; wr_row = 3'd0;
    wr_data = '0; req_valid = 1'b0; req_chan = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk({busy, done, found, row} == 6'd0, "R10 reset outputs",
        32'({busy, done, found, row}), 32'd0);
    @(negedge clk) rst = 1'b0;

    // channel 0 (R1: kind 0 base, kind 1 mask)
    wr(2'd0, 1'b0, 3'd0, 32'h0000_0000); wr(2'd1, 1'b0, 3'd0, 32'h1FFF_FFFF);
    wr(2'd0, 1'b0, 3'd1, 32'h0028_0001); wr(2'd1, 1'b0, 3'd1, 32'h0000_3FE0);
    wr(2'd0, 1'b0, 3'd2, 32'h0028_0001); wr(2'd1, 1'b0, 3'd2, 32'h0018_3FE0);
    wr(2'd0, 1'b0, 3'd3, 32'h0048_41A1); wr(2'd1, 1'b0, 3'd3, 32'h0000_0000);
    wr(2'd0, 1'b0, 3'd4, 32'h4060_0001); wr(2'd1, 1'b0, 3'd4, 32'h0000_3FE0);
    wr(2'd0, 1'b0, 3'd5, 32'h00A0_0001); wr(2'd1, 1'b0, 3'd5, 32'h0000_3FE0);
    wr(2'd0, 1'b0, 3'd6, 32'h0000_0000); wr(2'd1, 1'b0, 3'd6, 32'h1FFF_FFFF);
    wr(2'd0, 1'b0, 3'd7, 32'h00F8_0001); wr(2'd1, 1'b0, 3'd7, 32'h0000_3FE0);
    // channel 1
    wr(2'd0, 1'b1, 3'd0, 32'h0028_0001); wr(2'd1, 1'b1, 3'd0, 32'h0000_3FE0);
    wr(2'd0, 1'b1, 3'd1, 32'h0140_0001); wr(2'd1, 1'b1, 3'd1, 32'h0000_3FE0);
    wr(2'd0, 1'b1, 3'd2, 32'h0148_0001); wr(2'd1, 1'b1, 3'd2, 32'h0000_3FE0);
    wr(2'd0, 1'b1, 3'd3, 32'h0150_0001); wr(2'd1, 1'b1, 3'd3, 32'h0000_3FE0);
    for (int r = 4; r < 8; r++) begin
      wr(2'd0, 1'b1, 3'(r), 32'h0000_0000);
      wr(2'd1, 1'b1, 3'(r), 32'h0000_0000);
    end
    // R7 ch0 bad row 5 not swapped, ch1 bad row 2 swapped
    wr(2'd2, 1'b0, 3'd0, 32'h0000_005A);
    // R1 kind 3 writes nothing: an all-ones word would disturb ch0 row 1
    wr(2'd3, 1'b0, 3'd1, 32'hFFFF_FFFF);

    for (int i = 0; i < 14; i++) begin
      run_lookup(VECS[i].chan, VECS[i].addr, VECS[i].found, VECS[i].row,
                 int'(VECS[i].lat), $sformatf("R5 R6 R11 table[%0d]", i));
    end

    // R7 swap done on ch0: bad row 5 reported as spare rank 0
    wr(2'd2, 1'b0, 3'd0, 32'h0000_005B);
    run_lookup(1'b0, 32'h00A0_0040, 1'b1, 3'd0, 7, "R7 spare hit ch0");
    run_lookup(1'b0, 32'h0028_1234, 1'b1, 3'd1, 3, "R7 healthy row ch0");

    // R2 disable row 1 at run time: row 2 now claims the address
    wr(2'd0, 1'b0, 3'd1, 32'h0028_0000);
    run_lookup(1'b0, 32'h0028_1234, 1'b1, 3'd2, 4, "R2 disabled row skipped");

    // R1 mask rewrite widens ch1 row 3
    wr(2'd1, 1'b1, 3'd3, 32'h0018_3FE0);
    run_lookup(1'b1, 32'h0158_0000, 1'b1, 3'd3, 5, "R1 mask rewrite");

    // R9 request held while busy is ignored
    begin
      int lat;
      int extra;
      @(negedge clk);
      req_valid = 1'b1; req_chan = 1'b0; req_addr = 32'h00F8_0000;
      @(posedge clk);
      #1 req_addr = 32'h0028_1234;
      lat = 0;
      repeat (3) begin
        @(posedge clk);
        #1 lat++;
      end
      req_valid = 1'b0;
      while (!done && lat < 40) begin
        @(posedge clk);
        #1 lat++;
      end
      chk(row == 3'd7 && found, "R9 in-flight lookup kept", 32'(row), 32'd7);
      chk(lat == 9, "R9 R8 latency with held request", 32'(lat), 32'd9);
      extra = 0;
      repeat (6) begin
        @(posedge clk);
        #1 if (done) extra++;
      end
      chk(extra == 0, "R9 no extra done", 32'(extra), 32'd0);
      chk(row == 3'd7 && found && !busy, "R10 result held",
          32'({busy, found, row}), 32'({1'b0, 1'b1, 3'd7}));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule